// File: doc/BRIEF.md
# Timed Fuse and Lock Access Controller

This block is the control-register unit that an embedded CPU uses to program its lock bits and to read back the lock byte and the two fuse bytes. Software first writes an arming code to the control register. That opens a short window. The next store-type strobe (SPM) or load-type strobe (LPM) is then steered away from normal program memory. A store programs the lock bits from the 8-bit data operand. A load returns a lock or fuse byte on the read-data output, selected by the 16-bit Z pointer.

The window has a fixed length, counted in clock edges after the arming write. A store is accepted for longer than a load. The arming clears itself in four cases: when a request is served, when the window runs out, when a new control write replaces it, or when an EEPROM write is in progress. A load that the block does not serve still completes, but it is marked as not belonging to the controller, so the CPU takes the byte from program memory instead. The nonvolatile lock and fuse contents are modelled as registers. The fuse bytes are fixed by parameters.

Top module: `fuse_lock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `armed` is 0, `rd_valid`, `rd_own` and `rd_data` are 0, and `lock_q` holds LOCK_INIT (0x3F by default).
- R2: An accepted control write whose bits 6..0 equal 0001001 arms the unit. Bit 3 is the lock-select bit, bit 0 is the self-program-enable bit, and bit 7 is ignored. `armed` is 1 from the next cycle. An accepted write with any other code leaves the unit disarmed.
- R3: A store strobe sampled on the 1st to 4th rising edge after the arming write edge programs the lock bits and disarms the unit. A store strobe on the 5th edge or later changes nothing.
- R4: A served store sets `lock_q` to the old `lock_q` ANDed with data operand bits 5..0, whatever the Z pointer holds. Bits 5:4 of `lock_q` are the boot-section lock pair, bits 3:2 are the application-section lock pair, and bits 1:0 are the general lock pair.
- R5: A lock bit only ever moves from 1 (unprogrammed) to 0 (programmed), and `lock_q` changes only on an edge where a store strobe is sampled.
- R6: A load strobe sampled on the 1st to 3rd edge after the arming write is served. In the next cycle `rd_valid` and `rd_own` are 1, and `rd_data` is chosen by Z: 0x0000 gives the low fuse byte, 0x0001 gives the lock byte with bits 7 and 6 set to 1, 0x0003 gives the high fuse byte, and any other Z gives 0xFF. The unit disarms.
- R7: With no strobe, `armed` stays 1 for exactly four cycles after the arming write edge and then falls. A load on the 4th edge is not served.
- R8: A load strobe that is not served gives `rd_valid`=1, `rd_own`=0 and `rd_data`=0 in the next cycle. This holds whether the unit is disarmed, the window has expired, or the load comes right after a lock programming.
- R9: While `ee_busy` is 1, a control write is refused and changes nothing. An armed unit disarms on that edge and serves no load or store.
- R10: A strobe sampled on the same edge as an accepted control write is not served. A load passes through, a store leaves `lock_q` unchanged, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control-register write data |
| spm_stb | input | 1 | Store-to-program-memory instruction strobe |
| lpm_stb | input | 1 | Load-from-program-memory instruction strobe |
| zptr | input | 16 | Z pointer address |
| r0_data | input | 8 | Data operand register used by lock programming |
| ee_busy | input | 1 | EEPROM write in progress |
| armed | output | 1 | Lock-select and self-program-enable bits (both set) |
| rd_valid | output | 1 | A load strobe completed in the previous cycle |
| rd_own | output | 1 | The completed load was served by this unit |
| rd_data | output | 8 | Lock or fuse byte returned by a served load |
| lock_q | output | 6 | Stored lock bits |

## Verification
The hardest conditions to reach are at the edges of the window: a strobe on exactly the last edge a store is allowed, and a load on the one edge where a store would still be accepted but a load is not. The bench reaches these with a sweep. Each run re-arms from reset and places the strobe at every distance from 1 to 6 edges after the arming write, for both strobe types and for all four Z values of interest. An EEPROM-busy pulse is inserted inside an open window, and a strobe is made to collide with the arming write itself. These two cases cover the cancellation paths.

// File: rtl/fl_pkg.sv
package fl_pkg;
   localparam logic [6:0] ARM_CODE = 7'b0001001;

   typedef enum logic [1:0] {
      SEL_FUSE_LO = 2'd0,
      SEL_LOCK    = 2'd1,
      SEL_FUSE_HI = 2'd2,
      SEL_OTHER   = 2'd3
   } rd_sel_e;

   function automatic rd_sel_e decode_z(input logic [15:0] z);
      case (z)
         16'h0000: return SEL_FUSE_LO;
         16'h0001: return SEL_LOCK;
         16'h0003: return SEL_FUSE_HI;
         default:  return SEL_OTHER;
      endcase
   endfunction
endpackage

// File: rtl/fl_arm_timer.sv
module fl_arm_timer #(
   parameter int DATA_W  = 8,
   parameter int SPM_WIN = 4,
   parameter int LPM_WIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              ee_busy,
   input  logic              spm_stb,
   input  logic              lpm_stb,
   output logic              armed,
   output logic              spm_ok,
   output logic              lpm_ok
);
   import fl_pkg::*;

   localparam int CNT_W = $clog2(SPM_WIN + 1);
   localparam logic [CNT_W-1:0] SPM_LIM = CNT_W'(SPM_WIN);
   localparam logic [CNT_W-1:0] LPM_LIM = CNT_W'(LPM_WIN);

   logic [CNT_W-1:0] age_q;
   logic             we_ok;
   logic             code_hit;
   logic             live;

   assign we_ok    = ctl_we & ~ee_busy;
   assign code_hit = (ctl_wdata[6:0] == ARM_CODE);
   assign live     = armed & ~ee_busy & ~we_ok;
   assign spm_ok   = live & spm_stb & (age_q <= SPM_LIM);
   assign lpm_ok   = live & lpm_stb & ~spm_stb & (age_q <= LPM_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         age_q <= '0;
      end else if (we_ok) begin
         armed <= code_hit;
         age_q <= code_hit ? CNT_W'(1) : '0;
      end else if (armed) begin
         if (ee_busy || spm_ok || lpm_ok || age_q == SPM_LIM) begin
            armed <= 1'b0;
            age_q <= '0;
         end else begin
            age_q <= age_q + CNT_W'(1);
         end
      end
   end

   logic unused_hi;
   assign unused_hi = ^ctl_wdata[DATA_W-1:7];

   AST_AGE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (age_q >= CNT_W'(1) && age_q <= SPM_LIM)); // R7
   AST_LOAD_WINDOW_SHORTER: assert property (@(posedge clk) disable iff (!rst_n)
      lpm_ok |-> (armed && age_q <= LPM_LIM)); // R6
endmodule

// File: rtl/fl_lock_store.sv
module fl_lock_store #(
   parameter int DATA_W = 8,
   parameter int LOCK_W = 6,
   parameter logic [LOCK_W-1:0] LOCK_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic [DATA_W-1:0] r0_data,
   output logic [LOCK_W-1:0] lock_q
);
   for (genvar b = 0; b < LOCK_W; b++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)
            lock_q[b] <= LOCK_INIT[b];
         else if (prog && !r0_data[b])
            lock_q[b] <= 1'b0;
      end
   end

   logic unused_hi;
   assign unused_hi = ^r0_data[DATA_W-1:LOCK_W];

   AST_LOCK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lock_q & ~$past(lock_q)) == '0)); // R5
   AST_LOCK_AND_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      prog |=> (lock_q == ($past(lock_q) & $past(r0_data[LOCK_W-1:0])))); // R4
endmodule

// File: rtl/fl_read_mux.sv
module fl_read_mux #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int LOCK_W = 6,
   parameter logic [DATA_W-1:0] FUSE_LO = '0,
   parameter logic [DATA_W-1:0] FUSE_HI = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lpm_stb,
   input  logic              lpm_ok,
   input  logic [ADDR_W-1:0] zptr,
   input  logic [LOCK_W-1:0] lock_q,
   output logic              rd_valid,
   output logic              rd_own,
   output logic [DATA_W-1:0] rd_data
);
   import fl_pkg::*;

   localparam int PAD_W = DATA_W - LOCK_W;

   rd_sel_e           sel;
   logic [DATA_W-1:0] pick;

   assign sel = decode_z(16'(zptr));

   always_comb begin
      case (sel)
         SEL_FUSE_LO: pick = FUSE_LO;
         SEL_LOCK:    pick = {{PAD_W{1'b1}}, lock_q};
         SEL_FUSE_HI: pick = FUSE_HI;
         default:     pick = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_own   <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= lpm_stb;
         rd_own   <= lpm_ok;
         rd_data  <= lpm_ok ? pick : '0;
      end
   end

   AST_OWN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_own |-> rd_valid); // R8
   AST_VALID_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      lpm_stb |=> rd_valid); // R6
endmodule

// File: rtl/fuse_lock_ctrl.sv
module fuse_lock_ctrl #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 16,
   parameter int LOCK_W  = 6,
   parameter int SPM_WIN = 4,
   parameter int LPM_WIN = 3,
   parameter logic [LOCK_W-1:0] LOCK_INIT    = '1,
   parameter logic [DATA_W-1:0] FUSE_LO_INIT = 8'h62,
   parameter logic [DATA_W-1:0] FUSE_HI_INIT = 8'hDF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              spm_stb,
   input  logic              lpm_stb,
   input  logic [ADDR_W-1:0] zptr,
   input  logic [DATA_W-1:0] r0_data,
   input  logic              ee_busy,
   output logic              armed,
   output logic              rd_valid,
   output logic              rd_own,
   output logic [DATA_W-1:0] rd_data,
   output logic [LOCK_W-1:0] lock_q
);
   if (DATA_W != 8) begin : g_bad_data
      $error("fuse_lock_ctrl: DATA_W must be 8");
   end
   if (ADDR_W != 16) begin : g_bad_addr
      $error("fuse_lock_ctrl: ADDR_W must be 16");
   end
   if (LOCK_W < 1 || LOCK_W > DATA_W - 2) begin : g_bad_lock
      $error("fuse_lock_ctrl: LOCK_W out of range");
   end
   if (LPM_WIN < 1 || LPM_WIN > SPM_WIN) begin : g_bad_win
      $error("fuse_lock_ctrl: need 1 <= LPM_WIN <= SPM_WIN");
   end

   logic spm_ok;
   logic lpm_ok;

   fl_arm_timer #(.DATA_W(DATA_W), .SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)) u_arm (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ee_busy(ee_busy), .spm_stb(spm_stb), .lpm_stb(lpm_stb),
      .armed(armed), .spm_ok(spm_ok), .lpm_ok(lpm_ok)
   );

   fl_lock_store #(.DATA_W(DATA_W), .LOCK_W(LOCK_W), .LOCK_INIT(LOCK_INIT)) u_lock (
      .clk(clk), .rst_n(rst_n), .prog(spm_ok), .r0_data(r0_data), .lock_q(lock_q)
   );

   fl_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_W(LOCK_W),
                 .FUSE_LO(FUSE_LO_INIT), .FUSE_HI(FUSE_HI_INIT)) u_rd (
      .clk(clk), .rst_n(rst_n), .lpm_stb(lpm_stb), .lpm_ok(lpm_ok), .zptr(zptr),
      .lock_q(lock_q), .rd_valid(rd_valid), .rd_own(rd_own), .rd_data(rd_data)
   );

   AST_ARM_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ee_busy && ctl_wdata[6:0] == 7'b0001001) |=> armed); // R2
   AST_BUSY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ee_busy) |=> !armed); // R9
   AST_LOCK_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      !spm_stb |=> $stable(lock_q)); // R5
   AST_BUSY_NO_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      ee_busy |=> !rd_own); // R9
endmodule

// File: tb/test_fuse_lock_ctrl.sv
`timescale 1ns/1ps
module test_fuse_lock_ctrl;
   localparam logic [7:0] FLO = 8'h62;
   localparam logic [7:0] FHI = 8'hDF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_we = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic spm_stb = 1'b0;
   logic lpm_stb = 1'b0;
   logic [15:0] zptr = 16'h0000;
   logic [7:0] r0_data = 8'hFF;
   logic ee_busy = 1'b0;
   logic armed, rd_valid, rd_own;
   logic [7:0] rd_data;
   logic [5:0] lock_q;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fuse_lock_ctrl #(.LOCK_INIT(6'h3F), .FUSE_LO_INIT(FLO), .FUSE_HI_INIT(FHI)) i_fuse_lock_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .spm_stb(spm_stb), .lpm_stb(lpm_stb), .zptr(zptr), .r0_data(r0_data),
      .ee_busy(ee_busy), .armed(armed), .rd_valid(rd_valid), .rd_own(rd_own),
      .rd_data(rd_data), .lock_q(lock_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ctl_we = 0; spm_stb = 0; lpm_stb = 0; ee_busy = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // control write sampled on the next edge; returns just after that edge (negedge)
   task automatic wr_ctl(input logic [7:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   function automatic logic [7:0] exp_read(input int z, input logic [5:0] lk);
      case (z)
         0: return FLO;
         1: return {2'b11, lk};
         3: return FHI;
         default: return 8'hFF;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      @(negedge clk);
      chk("R1 armed", armed, 0);
      chk("R1 rd_valid", rd_valid, 0);
      chk("R1 rd_own", rd_own, 0);
      chk("R1 rd_data", rd_data, 0);
      chk("R1 lock", lock_q, 6'h3F);
      do_reset();
      chk("R1 lock after release", lock_q, 6'h3F);
      chk("R1 armed after release", armed, 0);

      // R7 timeout profile
      wr_ctl(8'h09);
      for (int k = 1; k <= 6; k++) begin
         chk("R7 armed over window", armed, (k <= 4) ? 1 : 0);
         @(negedge clk);
      end

      // R2 arming codes
      for (int c = 0; c < 256; c += 3) begin
         do_reset();
         wr_ctl(8'(c));
         chk("R2 arm code", armed, ((c & 8'h7F) == 8'h09) ? 1 : 0);
      end
      do_reset();
      wr_ctl(8'h89);
      chk("R2 bit7 ignored", armed, 1);
      wr_ctl(8'h0B);
      chk("R2 other code disarms", armed, 0);

      // R3/R4/R6/R7 sweep over strobe distance, type and Z
      for (int d = 1; d <= 6; d++) begin
         for (int op = 0; op < 2; op++) begin
            for (int z = 0; z < 4; z++) begin
               logic [7:0] r0v;
               logic [5:0] el;
               r0v = 8'h40 | 8'(6'h3F ^ 6'((d * 5 + z * 11 + 1) & 63));
               do_reset();
               wr_ctl(8'h09);
               repeat (d - 1) @(negedge clk);
               r0_data = r0v;
               if (op == 0) begin
                  zptr = 16'hA5A0 ^ 16'(z);
                  spm_stb = 1'b1;
               end else begin
                  zptr = 16'(z);
                  lpm_stb = 1'b1;
               end
               @(negedge clk);
               spm_stb = 0; lpm_stb = 0;
               if (op == 0) begin
                  el = (d <= 4) ? (6'h3F & r0v[5:0]) : 6'h3F;
                  chk("R3 R4 store in window", lock_q, el);
                  chk("R3 disarmed after store", armed, 0);
                  chk("R3 no read on store", rd_valid, 0);
               end else begin
                  chk("R6 R8 rd_valid", rd_valid, 1);
                  chk("R6 R7 rd_own", rd_own, (d <= 3) ? 1 : 0);
                  chk("R6 R8 rd_data", rd_data, (d <= 3) ? exp_read(z, 6'h3F) : 0);
                  chk("R6 disarm", armed, 0);
                  chk("R5 load keeps lock", lock_q, 6'h3F);
               end
            end
         end
      end

      // R4/R5 accumulation and lock readback; R8 load right after store
      do_reset();
      begin
         logic [5:0] exp_l;
         logic [7:0] pats [4];
         pats = '{8'hFA, 8'h2F, 8'hFF, 8'h3B};
         exp_l = 6'h3F;
         for (int i = 0; i < 4; i++) begin
            wr_ctl(8'h09);
            r0_data = pats[i]; spm_stb = 1'b1;
            @(negedge clk);
            spm_stb = 0;
            exp_l = exp_l & pats[i][5:0];
            chk("R4 R5 accumulated lock", lock_q, exp_l);
            lpm_stb = 1'b1; zptr = 16'h0001;
            @(negedge clk);
            lpm_stb = 0;
            chk("R8 load after store passes", rd_own, 0);
            chk("R8 load after store valid", rd_valid, 1);
            wr_ctl(8'h09);
            lpm_stb = 1'b1; zptr = 16'h0001;
            @(negedge clk);
            lpm_stb = 0;
            chk("R6 lock readback", rd_data, {2'b11, exp_l});
         end
         // R5 store while disarmed
         r0_data = 8'h00; spm_stb = 1'b1;
         @(negedge clk);
         spm_stb = 0;
         chk("R5 unarmed store ignored", lock_q, exp_l);
      end

      // R8 load while disarmed
      do_reset();
      lpm_stb = 1'b1; zptr = 16'h0000;
      @(negedge clk);
      lpm_stb = 0;
      chk("R8 unarmed rd_valid", rd_valid, 1);
      chk("R8 unarmed rd_own", rd_own, 0);
      chk("R8 unarmed rd_data", rd_data, 0);

      // R9 busy refuses write
      do_reset();
      ee_busy = 1'b1;
      wr_ctl(8'h09);
      chk("R9 write refused", armed, 0);
      ee_busy = 1'b0;
      // R9 busy inside window cancels
      wr_ctl(8'h09);
      ee_busy = 1'b1; lpm_stb = 1'b1; zptr = 16'h0001;
      @(negedge clk);
      ee_busy = 0; lpm_stb = 0;
      chk("R9 busy disarms", armed, 0);
      chk("R9 busy load not own", rd_own, 0);
      wr_ctl(8'h09);
      ee_busy = 1'b1; spm_stb = 1'b1; r0_data = 8'h00;
      @(negedge clk);
      ee_busy = 0; spm_stb = 0;
      chk("R9 busy store ignored", lock_q, 6'h3F);

      // R10 strobe on the arming edge
      do_reset();
      lpm_stb = 1'b1; zptr = 16'h0003;
      wr_ctl(8'h09);
      lpm_stb = 0;
      chk("R10 same-edge load not own", rd_own, 0);
      chk("R10 write still arms", armed, 1);
      wr_ctl(8'h09);
      spm_stb = 1'b1; r0_data = 8'h00;
      wr_ctl(8'h09);
      spm_stb = 0;
      chk("R10 same-edge store ignored", lock_q, 6'h3F);
      chk("R10 rearmed", armed, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule